// File: doc/BRIEF.md
# Input Duty to Output Duty Mapper

This block turns a measured input PWM duty into the duty a motor output stage should run at. Each 8-bit duty sample can be averaged over 4 or 8 samples, or used as it is. It is then placed on a two-point transfer curve: inside a programmable input window, the target duty moves in a straight line between a programmable minimum and a programmable maximum. Outside the window, a per-side selection decides what happens. An invert option mirrors the curve, so that a low input gives the high end.

The actual output duty does not jump to the target. It moves toward it in steps of 0.2%, one step every 128, 256 or 512 pulses of the output carrier. A fourth rate code makes it follow the target at once. During start-up, a hold input forces the output to a duty supplied from outside. When the hold is released, the same rate governs the ramp back to the curve.

All duties are carried in units of 0.1% (0 to 1000). Configuration pins are copied into a shadow register only on a recalculation strobe. The sample input is a valid/ready stream. The block applies back-pressure only in the cycle of the strobe: there `in_ready` is low, and a producer must keep `in_valid` and `in_duty` steady until it sees `in_ready` high.

Top module: `duty_curve_mapper`

## Requirements
- R1: Averaging select 0 or 3 passes each sample straight through; 1 outputs floor(sum/4) once every 4 accepted samples; 2 outputs floor(sum/8) once every 8; the curve input keeps its last value in between, and a recalculation strobe restarts the count.
- R2: Input code d means x = floor(d*1000/255); the lower threshold code a means floor(a*498/63); the upper threshold code b means 502 + floor(b*498/63).
- R3: An output duty code c (minimum or maximum) means min(floor(c*1000/126), 1000), so codes 126 and 127 both mean 1000.
- R4: With lo <= x <= hi and invert clear, target = omin + trunc((omax-omin)*(x-lo)/(hi-lo)), saturated to 0..1000.
- R5: Below the window (x < lo, invert clear) the target is omin when the below-select bit is 0, and 0 when it is 1.
- R6: Above the window (x > hi, invert clear) the target is omax when the above-select bit is 0, and 1000 when it is 1.
- R7: With invert set, the in-window position is hi-x instead of x-lo, x > hi follows the below-window rule and x < lo follows the above-window rule.
- R8: For rate codes 0, 1 and 2, while the output differs from the target, it moves toward the target by 2 (or by the remaining distance, if smaller) on the 128th, 256th or 512th carrier tick respectively, and never changes without a tick.
- R9: With rate code 3, the output equals the target one clock after the target.
- R10: While start_hold is high, the output equals start_duty saturated to 1000 one clock later, and the tick count is cleared; after release, the output slews per R8.
- R11: Configuration pins have no effect except in a cycle where recalc is high.
- R12: After reset the output and target are 0 and in_ready is high; in_ready is low in any cycle where recalc is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Duty sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_duty | input | 8 | Measured input duty code |
| carrier_tick | input | 1 | One-cycle pulse per output carrier period |
| recalc | input | 1 | Load configuration pins into shadow |
| cfg_avg_sel | input | 2 | Averaging select |
| cfg_in_lo | input | 6 | Lower input threshold code |
| cfg_in_hi | input | 6 | Upper input threshold code |
| cfg_out_min | input | 7 | Minimum output duty code |
| cfg_out_max | input | 7 | Maximum output duty code |
| cfg_below_zero | input | 1 | Below window: 0 holds minimum, 1 forces 0 |
| cfg_above_full | input | 1 | Above window: 0 holds maximum, 1 forces 1000 |
| cfg_invert | input | 1 | Reverse curve slope |
| cfg_rate | input | 2 | Slew rate code |
| start_hold | input | 1 | Start-up override active |
| start_duty | input | 10 | Start-up duty in 0.1% units |
| target_duty | output | 10 | Curve target in 0.1% units |
| out_duty | output | 10 | Actual output duty in 0.1% units |

## Verification
The embedded properties watch, on every cycle, that the slewed output never moves by more than one step and never moves without a tick. They also check that it snaps to the target in immediate mode, follows the start duty under hold, and that the shadow configuration and the target range only change as allowed. The exact curve values, the averaging arithmetic, the tick counts of 128, 256 and 512, and the ignoring of configuration pins between strobes can only be shown by the bench scenarios. In those scenarios the expected value is derived from the requirement formulas.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
  localparam int DUTY_W   = 10;
  localparam int DUTY_MAX = 1000;
  localparam int IN_W     = 8;

  typedef logic [DUTY_W-1:0] duty_t;

  typedef struct packed {
    logic [1:0] avg_sel;
    logic [5:0] in_lo;
    logic [5:0] in_hi;
    logic [6:0] out_min;
    logic [6:0] out_max;
    logic       below_zero;
    logic       above_full;
    logic       invert;
    logic [1:0] rate;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{avg_sel: 2'd0, in_lo: 6'd0, in_hi: 6'd63,
                                 out_min: 7'd0, out_max: 7'd126,
                                 below_zero: 1'b0, above_full: 1'b0,
                                 invert: 1'b0, rate: 2'd3};

  // input code to 0.1% units
  function automatic int in_permille(logic [IN_W-1:0] c);
    return (int'(c) * DUTY_MAX) / ((1 << IN_W) - 1);
  endfunction

  function automatic int lo_permille(logic [5:0] c);
    return (int'(c) * 498) / 63;
  endfunction

  function automatic int hi_permille(logic [5:0] c);
    return 502 + (int'(c) * 498) / 63;
  endfunction

  function automatic int out_permille(logic [6:0] c);
    int v;
    v = (int'(c) * DUTY_MAX) / 126;
    return (v > DUTY_MAX) ? DUTY_MAX : v;
  endfunction
endpackage

// File: rtl/duty_avg.sv
module duty_avg #(
  parameter int IN_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [1:0]      mode,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_data,
  output logic [IN_W-1:0] out_data
);
  localparam int ACC_W = IN_W + 3;

  logic [ACC_W-1:0] acc_q;
  logic [2:0]       cnt_q;
  logic [ACC_W-1:0] sum;
  logic [2:0]       last_idx;
  logic             pass;

  assign sum = acc_q + ACC_W'(in_data);

  always_comb begin
    pass     = 1'b0;
    last_idx = 3'd0;
    case (mode)
      2'd1:    last_idx = 3'd3;
      2'd2:    last_idx = 3'd7;
      default: pass = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      out_data <= '0;
    end else if (clr) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (in_valid) begin
      if (pass) begin
        out_data <= in_data;
      end else if (cnt_q == last_idx) begin
        out_data <= (mode == 2'd1) ? IN_W'(sum >> 2) : IN_W'(sum >> 3);
        acc_q    <= '0;
        cnt_q    <= '0;
      end else begin
        acc_q <= sum;
        cnt_q <= cnt_q + 3'd1;
      end
    end
  end

  AST_AVG_FOUR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (cnt_q < 3'd4)); // R1
  AST_AVG_PASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 || mode == 2'd3) |-> (acc_q == '0)); // R1
endmodule

// File: rtl/duty_curve.sv
module duty_curve
  import dmap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  cfg_t            cfg,
  input  logic [IN_W-1:0] x_code,
  output duty_t           target
);
  int   xi, lo, hi, omin, omax, pos, span, val;
  logic low_side, high_side;

  always_comb begin
    xi        = in_permille(x_code);
    lo        = lo_permille(cfg.in_lo);
    hi        = hi_permille(cfg.in_hi);
    omin      = out_permille(cfg.out_min);
    omax      = out_permille(cfg.out_max);
    span      = hi - lo;
    low_side  = cfg.invert ? (xi > hi) : (xi < lo);
    high_side = cfg.invert ? (xi < lo) : (xi > hi);
    pos       = cfg.invert ? (hi - xi) : (xi - lo);
    if (low_side)
      val = cfg.below_zero ? 0 : omin;
    else if (high_side)
      val = cfg.above_full ? DUTY_MAX : omax;
    else
      val = omin + ((omax - omin) * pos) / span;
    if (val < 0)        val = 0;
    if (val > DUTY_MAX) val = DUTY_MAX;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) target <= '0;
    else        target <= duty_t'(val);
  end

  AST_TARGET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    target <= duty_t'(DUTY_MAX)); // R4
  AST_ABOVE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg.above_full) && !$past(cfg.invert) &&
     in_permille($past(x_code)) > hi_permille($past(cfg.in_hi)))
    |-> (target == duty_t'(DUTY_MAX))); // R6
endmodule

// File: rtl/duty_slew.sv
module duty_slew
  import dmap_pkg::*;
#(
  parameter int STEP      = 2,
  parameter int BASE_LOG2 = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate,
  input  duty_t      target,
  input  logic       tick,
  input  logic       hold,
  input  duty_t      hold_duty,
  output duty_t      duty
);
  localparam int CNT_W = BASE_LOG2 + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  duty_t            stepped;

  always_comb begin
    limit = CNT_W'((1 << (BASE_LOG2 + int'(rate))) - 1);
    if (target > duty)
      stepped = (target - duty > duty_t'(STEP)) ? duty + duty_t'(STEP) : target;
    else
      stepped = (duty - target > duty_t'(STEP)) ? duty - duty_t'(STEP) : target;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty  <= '0;
      cnt_q <= '0;
    end else if (hold) begin
      duty  <= hold_duty;
      cnt_q <= '0;
    end else if (rate == 2'd3) begin
      duty  <= target;
      cnt_q <= '0;
    end else if (duty == target) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q >= limit) begin
        cnt_q <= '0;
        duty  <= stepped;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_SLEW_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rate) != 2'd3 && !$past(hold)) |->
    (int'(duty) <= int'($past(duty)) + STEP && int'(duty) + STEP >= int'($past(duty)))); // R8
  AST_SLEW_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rate) != 2'd3 && !$past(hold) && !$past(tick)) |-> $stable(duty)); // R8
  AST_SNAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rate) == 2'd3 && !$past(hold)) |-> (duty == $past(target))); // R9
  AST_HOLD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> (duty == $past(hold_duty))); // R10
endmodule

// File: rtl/duty_curve_mapper.sv
module duty_curve_mapper
  import dmap_pkg::*;
#(
  parameter int STEP      = 2,
  parameter int BASE_LOG2 = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_duty,
  input  logic        carrier_tick,
  input  logic        recalc,
  input  logic [1:0]  cfg_avg_sel,
  input  logic [5:0]  cfg_in_lo,
  input  logic [5:0]  cfg_in_hi,
  input  logic [6:0]  cfg_out_min,
  input  logic [6:0]  cfg_out_max,
  input  logic        cfg_below_zero,
  input  logic        cfg_above_full,
  input  logic        cfg_invert,
  input  logic [1:0]  cfg_rate,
  input  logic        start_hold,
  input  logic [9:0]  start_duty,
  output logic [9:0]  target_duty,
  output logic [9:0]  out_duty
);
  cfg_t            cfg_q;
  logic            ready_q;
  logic            accept;
  logic [IN_W-1:0] avg_code;
  duty_t           target;
  duty_t           hold_sat;
  duty_t           duty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RESET;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (recalc)
        cfg_q <= '{avg_sel: cfg_avg_sel, in_lo: cfg_in_lo, in_hi: cfg_in_hi,
                   out_min: cfg_out_min, out_max: cfg_out_max,
                   below_zero: cfg_below_zero, above_full: cfg_above_full,
                   invert: cfg_invert, rate: cfg_rate};
    end
  end

  assign in_ready = ready_q & ~recalc;
  assign accept   = in_valid & in_ready;
  assign hold_sat = (start_duty > duty_t'(DUTY_MAX)) ? duty_t'(DUTY_MAX) : start_duty;

  duty_avg #(.IN_W(IN_W)) u_avg (
    .clk(clk), .rst_n(rst_n), .clr(recalc), .mode(cfg_q.avg_sel),
    .in_valid(accept), .in_data(in_duty), .out_data(avg_code)
  );

  duty_curve u_curve (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .x_code(avg_code), .target(target)
  );

  duty_slew #(.STEP(STEP), .BASE_LOG2(BASE_LOG2)) u_slew (
    .clk(clk), .rst_n(rst_n), .rate(cfg_q.rate), .target(target),
    .tick(carrier_tick), .hold(start_hold), .hold_duty(hold_sat), .duty(duty)
  );

  assign target_duty = target;
  assign out_duty    = duty;

  AST_CFG_ONLY_ON_RECALC: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(recalc) |-> $stable(cfg_q)); // R11
  AST_NO_ACCEPT_IN_RECALC: assert property (@(posedge clk) disable iff (!rst_n)
    (recalc && in_valid) |=> $stable(avg_code)); // R12
endmodule

// File: tb/duty_curve_mapper_test.sv
module duty_curve_mapper_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, carrier_tick = 0, recalc = 0;
  logic [7:0] in_duty = 0;
  logic [1:0] b_avg = 0, b_rate = 3;
  logic [5:0] b_lo = 0, b_hi = 63;
  logic [6:0] b_min = 0, b_max = 126;
  logic b_bz = 0, b_af = 0, b_inv = 0;
  logic start_hold = 0;
  logic [9:0] start_duty = 0;
  logic [9:0] target_duty, out_duty;

  int a_lo = 0, a_hi = 63, a_min = 0, a_max = 126, a_bz = 0, a_af = 0, a_inv = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  duty_curve_mapper uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_duty(in_duty), .carrier_tick(carrier_tick), .recalc(recalc),
    .cfg_avg_sel(b_avg), .cfg_in_lo(b_lo), .cfg_in_hi(b_hi),
    .cfg_out_min(b_min), .cfg_out_max(b_max), .cfg_below_zero(b_bz),
    .cfg_above_full(b_af), .cfg_invert(b_inv), .cfg_rate(b_rate),
    .start_hold(start_hold), .start_duty(start_duty),
    .target_duty(target_duty), .out_duty(out_duty)
  );

  function automatic int pm_out(int c);
    int v = (c * 1000) / 126;
    return (v > 1000) ? 1000 : v;
  endfunction

  // expected target from requirement formulas R2..R7
  function automatic int ref_target(int d);
    int x, lo, hi, omin, omax, v;
    bit ls, hs;
    x = (d * 1000) / 255;
    lo = (a_lo * 498) / 63;
    hi = 502 + (a_hi * 498) / 63;
    omin = pm_out(a_min);
    omax = pm_out(a_max);
    ls = a_inv != 0 ? (x > hi) : (x < lo);
    hs = a_inv != 0 ? (x < lo) : (x > hi);
    if (ls) v = (a_bz != 0) ? 0 : omin;
    else if (hs) v = (a_af != 0) ? 1000 : omax;
    else v = omin + ((omax - omin) * (a_inv != 0 ? hi - x : x - lo)) / (hi - lo);
    if (v < 0) v = 0;
    if (v > 1000) v = 1000;
    return v;
  endfunction

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_cfg();
    @(negedge clk);
    recalc = 1;
    @(negedge clk);
    recalc = 0;
    a_lo = b_lo; a_hi = b_hi; a_min = b_min; a_max = b_max;
    a_bz = b_bz; a_af = b_af; a_inv = b_inv;
  endtask

  task automatic send(int d);
    @(negedge clk);
    in_valid = 1;
    in_duty = 8'(d);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    carrier_tick = 1;
    repeat (n) @(negedge clk);
    carrier_tick = 0;
  endtask

  task automatic set_default(logic [1:0] avg, logic [1:0] rate);
    b_avg = avg; b_rate = rate; b_lo = 0; b_hi = 63; b_min = 0; b_max = 126;
    b_bz = 0; b_af = 0; b_inv = 0;
  endtask

  task automatic t_reset();
    settle(2);
    check("R12 reset out_duty", int'(out_duty), 0);
    check("R12 reset target", int'(target_duty), 0);
    check("R12 reset ready", int'(in_ready), 1);
    @(negedge clk);
    recalc = 1;
    #1 check("R12 ready low on recalc", int'(in_ready), 0);
    @(negedge clk);
    recalc = 0;
  endtask

  task automatic t_linear();
    set_default(0, 3); apply_cfg();
    send(128); settle(4);
    check("R2 R4 default curve", int'(target_duty), ref_target(128));
    check("R9 snap", int'(out_duty), ref_target(128));
  endtask

  task automatic t_window();
    set_default(0, 3);
    b_lo = 20; b_hi = 40; b_min = 20; b_max = 100; apply_cfg();
    send(128); settle(4);
    check("R4 window interp", int'(target_duty), ref_target(128));
    send(10); settle(4);
    check("R5 below hold min", int'(target_duty), ref_target(10));
    b_bz = 1; apply_cfg(); settle(3);
    check("R5 below zero", int'(target_duty), 0);
    send(250); settle(4);
    check("R6 above hold max", int'(target_duty), ref_target(250));
    b_af = 1; apply_cfg(); settle(3);
    check("R6 above full", int'(target_duty), 1000);
  endtask

  task automatic t_invert();
    b_inv = 1; b_af = 1; b_bz = 0; apply_cfg();
    send(10); settle(4);
    check("R7 invert low input high end", int'(target_duty), 1000);
    send(250); settle(4);
    check("R7 invert high input low end", int'(target_duty), ref_target(250));
    send(128); settle(4);
    check("R7 invert mirrored interp", int'(target_duty), ref_target(128));
  endtask

  task automatic t_codes();
    set_default(0, 3); b_min = 127; b_max = 126; apply_cfg();
    send(0); settle(4);
    check("R3 code 127 full", int'(target_duty), 1000);
    b_min = 63; apply_cfg(); settle(3);
    check("R3 code 63", int'(target_duty), 500);
  endtask

  task automatic t_cfg_ignored();
    set_default(0, 3); apply_cfg();
    b_lo = 40; b_min = 90; b_inv = 1;
    send(100); settle(4);
    check("R11 pins ignored", int'(target_duty), ref_target(100));
    set_default(0, 3);
  endtask

  task automatic t_avg();
    int last;
    set_default(0, 3); apply_cfg();
    send(200); settle(3);
    b_avg = 1; apply_cfg();
    send(10); send(20); send(30); settle(4);
    check("R1 mean4 pending", int'(target_duty), ref_target(200));
    send(41); settle(4);
    check("R1 mean4 result", int'(target_duty), ref_target(25));
    b_avg = 2; apply_cfg();
    for (int i = 0; i < 7; i++) send(100 + i);
    settle(4);
    check("R1 mean8 pending", int'(target_duty), ref_target(25));
    send(107); settle(4);
    check("R1 mean8 result", int'(target_duty), ref_target(103));
    b_avg = 3; apply_cfg();
    send(60); settle(4);
    last = ref_target(60);
    check("R1 code3 none", int'(target_duty), last);
  endtask

  task automatic t_slew();
    set_default(0, 3); apply_cfg();
    send(128); settle(4);
    b_rate = 0; apply_cfg();
    send(200); settle(4);
    check("R8 target moved", int'(target_duty), ref_target(200));
    check("R8 no tick no move", int'(out_duty), 501);
    ticks(127);
    check("R8 rate0 before 128", int'(out_duty), 501);
    ticks(1);
    check("R8 rate0 at 128", int'(out_duty), 503);
    b_rate = 2; apply_cfg();
    ticks(511);
    check("R8 rate2 before 512", int'(out_duty), 503);
    ticks(1);
    check("R8 rate2 at 512", int'(out_duty), 505);
  endtask

  task automatic t_hold();
    b_rate = 1; apply_cfg();
    @(negedge clk);
    start_hold = 1; start_duty = 10'd1020;
    settle(2);
    check("R10 hold saturates", int'(out_duty), 1000);
    start_duty = 10'd300;
    settle(2);
    check("R10 hold follows", int'(out_duty), 300);
    start_hold = 0;
    ticks(255);
    check("R10 release before 256", int'(out_duty), 300);
    ticks(1);
    check("R10 release at 256", int'(out_duty), 302);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1;
    t_reset();
    t_linear();
    t_window();
    t_invert();
    t_codes();
    t_cfg_ignored();
    t_avg();
    t_slew();
    t_hold();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule